// File: doc/BRIEF.md
# Digital PLL Lock Detector

This block decides whether a phase-locked loop has settled by timing the phase error of every phase-detector cycle. It watches the UP and DOWN pulse outputs of a phase-frequency detector and measures their width with a fast sampling clock. The two inputs are resynchronised through two flip-flops before they are measured. The phase error of one cycle is the number of sampling ticks during which UP or DOWN (or both) is active. That width is captured when the activity ends. If the inputs stay quiet for a full idle window, the block counts that window as one cycle with zero phase error.

Lock detection uses hysteresis. While hunting, the block counts consecutive "tight" cycles, whose width is below `TIGHT_TICKS`. A one-bit select sets whether three or five such cycles are needed before the lock flag rises. Once the flag is high, only a single cycle wider than `LOOSE_TICKS` drops it. Widths between the two thresholds neither build lock nor break it, but while hunting any cycle at or above the tight threshold restarts the count.

Top module: `pll_lock_detect`

## Requirements
- R1: A synchronous active-high reset clears the good-cycle count and drives `lock_o` low.
- R2: With `cnt_sel_i` = 0, `lock_o` rises after three consecutive cycles of width strictly less than `TIGHT_TICKS`.
- R3: With `cnt_sel_i` = 1, `lock_o` rises only after five consecutive cycles of width strictly less than `TIGHT_TICKS`.
- R4: While locked, a single cycle of width strictly greater than `LOOSE_TICKS` drops `lock_o`. Any width up to and including `LOOSE_TICKS` leaves it high.
- R5: While hunting, a cycle of width at or above `TIGHT_TICKS` resets the consecutive count to zero, so a full new run is then needed.
- R6: The width of a cycle is the number of sampling ticks in which UP or DOWN is high, taken as a union. A pulse on DOWN alone and overlapping UP/DOWN pulses are measured in the same way as UP alone.
- R7: An interval of `IDLE_TICKS` sampling ticks with neither input active counts as one cycle of zero width.
- R8: The lock decision for a cycle appears on `lock_o` three sampling edges after the first edge that samples the end of its pulse: two synchroniser stages, one measurement register and the lock register. Before that, `lock_o` keeps its old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast sampling clock |
| rst_i | input | 1 | Synchronous reset, active high |
| up_i | input | 1 | UP pulse from the phase detector (asynchronous) |
| dn_i | input | 1 | DOWN pulse from the phase detector (asynchronous) |
| cnt_sel_i | input | 1 | 0: three tight cycles to lock, 1: five |
| lock_o | output | 1 | Lock flag, active high |

## Verification
The bench changes inputs on falling clock edges. A pulse's end is first sampled on edge k, and its lock decision is due right after edge k+3. The bench therefore samples `lock_o` just after edge k+2 and expects the previous value there. It samples again just after edge k+3 and expects the new decision there. The gap before the next pulse is kept well below the idle window, so that no zero-width cycle slips in unless a test asks for one. The idle test waits for more than a whole idle window before it samples.

// File: rtl/pll_lock_pkg.sv
package pll_lock_pkg;

    localparam int MEAS_BITS = 8;
    localparam int GOOD_BITS = 3;

    typedef struct packed {
        logic                 vld;
        logic [MEAS_BITS-1:0] width;
    } meas_t;

    typedef enum logic {
        ST_HUNT   = 1'b0,
        ST_LOCKED = 1'b1
    } lock_state_e;

    function automatic logic [GOOD_BITS-1:0] need_count(input logic sel);
        return sel ? GOOD_BITS'(5) : GOOD_BITS'(3);
    endfunction

endpackage

// File: rtl/pll_lock_sync.sv
module pll_lock_sync #(
    parameter int STAGES = 2,
    parameter int BITS   = 2
) (
    input  logic            clk_i,
    input  logic            rst_i,
    input  logic [BITS-1:0] d_i,
    output logic [BITS-1:0] q_o
);
    logic [STAGES-1:0] chain [BITS];

    for (genvar b = 0; b < BITS; b++) begin : g_bit
        always_ff @(posedge clk_i) begin
            if (rst_i) chain[b] <= '0;
            else       chain[b] <= {chain[b][STAGES-2:0], d_i[b]};
        end
        assign q_o[b] = chain[b][STAGES-1];
    end
endmodule

// File: rtl/pll_lock_meas.sv
module pll_lock_meas
    import pll_lock_pkg::*;
#(
    parameter int LOOSE_TICKS = 10,
    parameter int IDLE_TICKS  = 40
) (
    input  logic  clk_i,
    input  logic  rst_i,
    input  logic  act_i,
    output meas_t meas_o
);
    localparam int IDLE_BITS = $clog2(IDLE_TICKS + 1);
    localparam logic [MEAS_BITS-1:0] SAT_W   = MEAS_BITS'(LOOSE_TICKS + 1);
    localparam logic [IDLE_BITS-1:0] IDLE_END = IDLE_BITS'(IDLE_TICKS - 1);

    logic                 act_q;
    logic [MEAS_BITS-1:0] width_q;
    logic [IDLE_BITS-1:0] idle_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            act_q   <= 1'b0;
            width_q <= '0;
            idle_q  <= '0;
            meas_o  <= '0;
        end else begin
            act_q      <= act_i;
            meas_o.vld <= 1'b0;
            if (act_i) begin
                width_q <= (width_q == SAT_W) ? SAT_W : width_q + 1'b1;
                idle_q  <= '0;
            end else if (act_q) begin
                meas_o.vld   <= 1'b1;
                meas_o.width <= width_q;
                width_q      <= '0;
                idle_q       <= '0;
            end else if (idle_q == IDLE_END) begin
                meas_o.vld   <= 1'b1;
                meas_o.width <= '0;
                idle_q       <= '0;
            end else begin
                idle_q <= idle_q + 1'b1;
            end
        end
    end

    // R6: a measurement is a single-cycle strobe
    p_single_strobe_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        meas_o.vld |=> !meas_o.vld);

    // R6: the end of activity produces a measurement on the next edge
    p_fall_meas_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        (act_q && !act_i) |=> meas_o.vld);
endmodule

// File: rtl/pll_lock_fsm.sv
module pll_lock_fsm
    import pll_lock_pkg::*;
#(
    parameter int TIGHT_TICKS = 6,
    parameter int LOOSE_TICKS = 10
) (
    input  logic  clk_i,
    input  logic  rst_i,
    input  logic  sel_i,
    input  meas_t meas_i,
    output logic  lock_o
);
    localparam logic [MEAS_BITS-1:0] TIGHT_W = MEAS_BITS'(TIGHT_TICKS);
    localparam logic [MEAS_BITS-1:0] LOOSE_W = MEAS_BITS'(LOOSE_TICKS);

    lock_state_e          state_q;
    logic [GOOD_BITS-1:0] good_q;
    logic [GOOD_BITS-1:0] need;
    logic                 tight, wide;

    always_comb begin
        need  = need_count(sel_i);
        tight = meas_i.width < TIGHT_W;
        wide  = meas_i.width > LOOSE_W;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= ST_HUNT;
            good_q  <= '0;
        end else if (meas_i.vld) begin
            unique case (state_q)
                ST_HUNT: begin
                    if (!tight) begin
                        good_q <= '0;
                    end else if (good_q + 1'b1 >= need) begin
                        state_q <= ST_LOCKED;
                        good_q  <= '0;
                    end else begin
                        good_q <= good_q + 1'b1;
                    end
                end
                ST_LOCKED: begin
                    if (wide) begin
                        state_q <= ST_HUNT;
                        good_q  <= '0;
                    end
                end
                default: state_q <= ST_HUNT;
            endcase
        end
    end

    assign lock_o = (state_q == ST_LOCKED);

    // R2 / R3: lock rises only right after a tight measurement
    p_rise_tight_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(lock_o) |-> $past(meas_i.vld) && ($past(meas_i.width) < TIGHT_W));

    // R4: lock falls only right after a wide measurement
    p_fall_wide_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(lock_o) |-> $past(meas_i.vld) && ($past(meas_i.width) > LOOSE_W));

    // R3: the run count never reaches the largest requirement
    p_good_bound_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        good_q < GOOD_BITS'(5));

    // R5: a non-tight cycle while hunting clears the run
    p_run_clear_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        (meas_i.vld && !lock_o && !tight) |=> (good_q == '0) && !lock_o);
endmodule

// File: rtl/pll_lock_detect.sv
module pll_lock_detect
    import pll_lock_pkg::*;
#(
    parameter int TIGHT_TICKS = 6,
    parameter int LOOSE_TICKS = 10,
    parameter int IDLE_TICKS  = 40
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic up_i,
    input  logic dn_i,
    input  logic cnt_sel_i,
    output logic lock_o
);
    logic [1:0] pd_sync;
    logic       act;
    meas_t      meas;

    pll_lock_sync #(.STAGES(2), .BITS(2)) u_sync (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .d_i   ({dn_i, up_i}),
        .q_o   (pd_sync)
    );

    assign act = |pd_sync;

    pll_lock_meas #(.LOOSE_TICKS(LOOSE_TICKS), .IDLE_TICKS(IDLE_TICKS)) u_meas (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .act_i  (act),
        .meas_o (meas)
    );

    pll_lock_fsm #(.TIGHT_TICKS(TIGHT_TICKS), .LOOSE_TICKS(LOOSE_TICKS)) u_fsm (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .sel_i  (cnt_sel_i),
        .meas_i (meas),
        .lock_o (lock_o)
    );

    initial begin
        p_thresh_order_r4: assert (TIGHT_TICKS < LOOSE_TICKS && LOOSE_TICKS + 1 < 2**MEAS_BITS);
    end

    // R1: lock is low in the cycle after a reset
    p_reset_clear_r1: assert property (@(posedge clk_i)
        rst_i |=> !lock_o);
endmodule

// File: tb/tb_pll_lock_detect.sv
module tb_pll_lock_detect;
    localparam int TIGHT = 6;
    localparam int LOOSE = 10;
    localparam int IDLE  = 40;

    logic clk = 1'b0;
    logic rst, up, dn, sel;
    logic lock;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;
    bit exp_lock;
    int exp_good;

    always #4 clk = ~clk;

    pll_lock_detect #(.TIGHT_TICKS(TIGHT), .LOOSE_TICKS(LOOSE), .IDLE_TICKS(IDLE)) dut (
        .clk_i(clk), .rst_i(rst), .up_i(up), .dn_i(dn), .cnt_sel_i(sel), .lock_o(lock)
    );

    task automatic check(input logic got, input logic exp, input string req);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: lock_o=%0b expected %0b at %0t", req, got, exp, $time);
        end
    endtask

    task automatic model(input int w);
        int need = sel ? 5 : 3;
        if (!exp_lock) begin
            if (w < TIGHT) begin
                exp_good++;
                if (exp_good >= need) begin
                    exp_lock = 1'b1;
                    exp_good = 0;
                end
            end else exp_good = 0;
        end else if (w > LOOSE) begin
            exp_lock = 1'b0;
            exp_good = 0;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; up = 1'b0; dn = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        exp_lock = 1'b0;
        exp_good = 0;
        #1 check(lock, 1'b0, "R1 reset");
    endtask

    // mode 0: UP only, 1: DOWN only, 2: UP then overlapping DOWN
    task automatic pulse(input int w, input int mode, input string req);
        bit old = exp_lock;
        @(negedge clk);
        if (mode == 1) dn = 1'b1;
        else           up = 1'b1;
        if (mode == 2 && w >= 2) begin
            repeat (w / 2) @(negedge clk);
            dn = 1'b1;
            @(negedge clk);
            up = 1'b0;
            repeat (w - w / 2 - 1) @(negedge clk);
        end else begin
            repeat (w) @(negedge clk);
        end
        up = 1'b0; dn = 1'b0;
        model(w);
        repeat (3) @(posedge clk);
        #1 check(lock, old, "R8 not yet");
        @(posedge clk);
        #1 check(lock, exp_lock, req);
        repeat (6) @(posedge clk);
    endtask

    initial begin
        rst = 1'b1; up = 1'b0; dn = 1'b0; sel = 1'b0;
        repeat (2) @(posedge clk);
        do_reset();

        // R2 / R3: run length for each select value
        for (int s = 0; s < 2; s++) begin
            sel = s[0];
            do_reset();
            for (int k = 1; k <= 6; k++)
                pulse(2, k % 3, s ? "R3 run length" : "R2 run length");
        end

        // R4 / R5 / R6: sweep the width of one cycle in both states
        for (int s = 0; s < 2; s++) begin
            sel = s[0];
            for (int w = 1; w <= 14; w++) begin
                do_reset();
                for (int k = 0; k < (s ? 5 : 3); k++) pulse(1, 0, "R2 lock up");
                pulse(w, w % 3, "R4 locked width sweep");
                pulse(TIGHT - 1, 1, "R6 DOWN width");
                do_reset();
                for (int k = 0; k < (s ? 4 : 2); k++) pulse(3, 2, "R6 overlap run");
                pulse(w, 0, "R5 hunting width sweep");
                pulse(1, 0, "R5 after restart");
            end
        end

        // R7: a quiet window counts as a zero-width cycle
        sel = 1'b0;
        do_reset();
        pulse(2, 0, "R7 prep");
        pulse(2, 0, "R7 prep");
        repeat (IDLE / 2) @(posedge clk);
        #1 check(lock, 1'b0, "R7 short quiet gap");
        repeat (IDLE + 10) @(posedge clk);
        #1 check(lock, 1'b1, "R7 idle window");
        repeat (3 * IDLE) @(posedge clk);
        #1 check(lock, 1'b1, "R7 idle keeps lock");

        // R1: reset while locked
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1 check(lock, 1'b0, "R1 reset while locked");
        rst = 1'b0;

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule